// File: doc/BRIEF.md
# Receive Ring Packet Writer

This block places incoming Ethernet frames into a circular packet memory. The memory is split into 256-byte pages. Four page numbers set the ring: the first page, the page just past the last page, the current page where the next frame begins, and the boundary page that the host has not yet released. When a frame starts, the block checks the free space between the current page and the boundary. If the frame fits, the block stores the payload four bytes into the current page. A frame shorter than the minimum is padded with zeros. The block then fills in a four-byte header in front of the payload and moves the current page to the page after the frame.

The host reads frames out of the ring through some other path. It moves the boundary page forward as it consumes them, and it clears the receive flag. The block takes frame bytes one per cycle over a valid/ready handshake. The first byte of a frame is marked start and the last is marked end. The block has a single byte-wide write port to the packet memory. It has no read path, no address filtering and no CRC check.

Top module: `rxr_ring_writer`

## Requirements
- R1: When a frame starts with `halt` low, the block accepts it only if the ring has at least MAX_FRAME+4 (1518) bytes free. Free space is (boundary−current)×256 when current < boundary. Otherwise it is (stop−start)×256 − (current−boundary)×256. All of these are page numbers.
- R2: While `halt` is high, every frame that starts is rejected.
- R3: For a rejected frame, `in_ready` stays high until its end byte. No memory write occurs, and `cur_pg` keeps its value.
- R4: An accepted frame of fewer than MIN_FRAME (60) bytes gets zero bytes after its last byte until 60 bytes are stored.
- R5: The header goes to the frame's base page at offsets 0 to 3. The bytes are: receive status, next page, low byte of (stored length+4), high byte of (stored length+4). The stored length includes padding.
- R6: Payload byte i goes to address base×256+4+i. When an address reaches stop×256, it continues at start×256.
- R7: The next page is base + ceil((stored length+8)/256). If the result is at or beyond the stop page, (stop−start) is subtracted.
- R8: The receive status is 0x01. It is 0x21 when bit 0 of the frame's first byte (the group bit) is 1. The value also appears on `rx_status` once the frame is complete.
- R9: After the last header byte, `cur_pg` takes the next page and `rx_irq` is set. `irq_clr` clears `rx_irq`. At any other time `cur_pg` changes only through `cur_pg_load`.
- R10: `in_ready` is high after reset. It is low only while padding or header bytes are being written, which happens after an accepted end byte.
- R11: A `cur_pg_load` pulse writes `cur_pg_wdata` into `cur_pg`.
- R12: Bytes offered while idle without the start marker are consumed and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Receiver stopped; new frames are rejected |
| cfg_start_pg | input | PG_W | First page of the ring |
| cfg_stop_pg | input | PG_W | Page just past the ring |
| cfg_bndry_pg | input | PG_W | Boundary page released by the host |
| cur_pg_load | input | 1 | Load `cur_pg` from `cur_pg_wdata` |
| cur_pg_wdata | input | PG_W | Host value for the current page |
| irq_clr | input | 1 | Clears `rx_irq` |
| in_valid | input | 1 | Frame byte valid |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | PG_W+8 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| cur_pg | output | PG_W | Current page |
| rx_status | output | 8 | Status of the last stored frame |
| rx_irq | output | 1 | Frame-received flag |

## Verification
The hardest conditions to reach from the ports are the exact edges of the free-space test and a frame whose payload and padding cross the stop page. The bench uses `cur_pg_load` to place the current page and sets the boundary directly. It sweeps every pair of current and boundary pages in an eight-page ring, which hits both sides of the 1518-byte limit and the current-equals-boundary case. It then starts frames of lengths around 60 bytes and around page multiples in the last page of the ring. This forces the data, the padding and the next-page computation to wrap, and each result is compared with addresses computed in the bench.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int PAGE_SHIFT = 8;
    localparam int PAGE_BYTES = 1 << PAGE_SHIFT;
    localparam int HDR_LEN    = 4;
    localparam int FCS_LEN    = 4;

    localparam logic [7:0] RS_GOOD  = 8'h01;
    localparam logic [7:0] RS_GROUP = 8'h20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_DROP,
        ST_PAD,
        ST_HDR
    } rx_state_e;

    typedef struct packed {
        logic [7:0] len_hi;
        logic [7:0] len_lo;
        logic [7:0] nxt;
        logic [7:0] status;
    } rx_hdr_t;

    // free bytes between the write page and the host boundary
    function automatic int ring_free(input int cur, input int bnd,
                                     input int lo, input int hi);
        if (cur < bnd)
            return (bnd - cur) * PAGE_BYTES;
        return (hi - lo) * PAGE_BYTES - (cur - bnd) * PAGE_BYTES;
    endfunction

    // page where the following frame begins
    function automatic int next_page(input int cur, input int len,
                                     input int lo, input int hi);
        int n;
        n = cur + ((len + HDR_LEN + FCS_LEN + PAGE_BYTES - 1) >> PAGE_SHIFT);
        if (n >= hi)
            n = n - (hi - lo);
        return n;
    endfunction

endpackage

// File: rtl/rxr_space_chk.sv
module rxr_space_chk #(
    parameter int PG_W      = 8,
    parameter int MAX_FRAME = 1514
) (
    input  logic            halt,
    input  logic [PG_W-1:0] cur_pg,
    input  logic [PG_W-1:0] bndry_pg,
    input  logic [PG_W-1:0] ring_lo,
    input  logic [PG_W-1:0] ring_hi,
    output logic            fits
);
    import rxr_pkg::*;

    localparam int NEED_BYTES = MAX_FRAME + FCS_LEN;

    int free_b;

    always_comb begin
        free_b = ring_free(int'(cur_pg), int'(bndry_pg), int'(ring_lo), int'(ring_hi));
        fits   = !halt && (free_b >= NEED_BYTES);
    end

endmodule

// File: rtl/rxr_wptr.sv
module rxr_wptr #(
    parameter int PG_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [PG_W-1:0]      load_pg,
    input  logic                 step,
    input  logic [PG_W-1:0]      ring_lo,
    input  logic [PG_W-1:0]      ring_hi,
    output logic [PG_W+8-1:0]    addr
);
    import rxr_pkg::*;

    localparam int AW = PG_W + 8;

    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_inc;
    logic [AW-1:0] addr_nxt;

    always_comb begin
        addr     = load ? {load_pg, 8'(HDR_LEN)} : addr_q;
        addr_inc = addr + AW'(1);
        addr_nxt = (addr_inc == {ring_hi, 8'h00}) ? {ring_lo, 8'h00} : addr_inc;
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (load || step)
            addr_q <= addr_nxt;
    end

endmodule

// File: rtl/rxr_hdr_gen.sv
module rxr_hdr_gen #(
    parameter int PG_W  = 8,
    parameter int LEN_W = 16
) (
    input  logic [PG_W-1:0]  frame_pg,
    input  logic [LEN_W-1:0] stored_len,
    input  logic             group_bit,
    input  logic [PG_W-1:0]  ring_lo,
    input  logic [PG_W-1:0]  ring_hi,
    output rxr_pkg::rx_hdr_t hdr,
    output logic [PG_W-1:0]  nxt_pg
);
    import rxr_pkg::*;

    int               nxt_i;
    logic [LEN_W-1:0] total;

    always_comb begin
        nxt_i      = next_page(int'(frame_pg), int'(stored_len), int'(ring_lo), int'(ring_hi));
        nxt_pg     = PG_W'(nxt_i);
        total      = stored_len + LEN_W'(HDR_LEN);
        hdr.status = group_bit ? (RS_GOOD | RS_GROUP) : RS_GOOD;
        hdr.nxt    = 8'(nxt_pg);
        hdr.len_lo = total[7:0];
        hdr.len_hi = total[15:8];
    end

endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer #(
    parameter int PG_W      = 8,
    parameter int MAX_FRAME = 1514,
    parameter int MIN_FRAME = 60,
    localparam int AW       = PG_W + 8,
    localparam int LEN_W    = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            halt,
    input  logic [PG_W-1:0] cfg_start_pg,
    input  logic [PG_W-1:0] cfg_stop_pg,
    input  logic [PG_W-1:0] cfg_bndry_pg,
    input  logic            cur_pg_load,
    input  logic [PG_W-1:0] cur_pg_wdata,
    input  logic            irq_clr,
    input  logic            in_valid,
    input  logic            in_sof,
    input  logic            in_eof,
    input  logic [7:0]      in_data,
    output logic            in_ready,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [7:0]      mem_wdata,
    output logic [PG_W-1:0] cur_pg,
    output logic [7:0]      rx_status,
    output logic            rx_irq
);
    import rxr_pkg::*;

    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);

    rx_state_e        st, st_n;
    logic [LEN_W-1:0] len_q, len_n;
    logic [1:0]       hidx_q, hidx_n;
    logic             grp_q, grp_n;
    logic [PG_W-1:0]  fpg_q, fpg_n;

    logic             fits;
    logic             fire;
    logic             wp_load, wp_step;
    logic [AW-1:0]    wp_addr;
    rx_hdr_t          hdr;
    logic [PG_W-1:0]  nxt_pg;
    logic             done;

    logic             wr_en;
    logic [AW-1:0]    wr_addr;
    logic [7:0]       wr_data;

    rxr_space_chk #(.PG_W(PG_W), .MAX_FRAME(MAX_FRAME)) u_space (
        .halt     (halt),
        .cur_pg   (cur_pg),
        .bndry_pg (cfg_bndry_pg),
        .ring_lo  (cfg_start_pg),
        .ring_hi  (cfg_stop_pg),
        .fits     (fits)
    );

    rxr_wptr #(.PG_W(PG_W)) u_wptr (
        .clk     (clk),
        .rst     (rst),
        .load    (wp_load),
        .load_pg (cur_pg),
        .step    (wp_step),
        .ring_lo (cfg_start_pg),
        .ring_hi (cfg_stop_pg),
        .addr    (wp_addr)
    );

    rxr_hdr_gen #(.PG_W(PG_W), .LEN_W(LEN_W)) u_hdr (
        .frame_pg   (fpg_q),
        .stored_len (len_q),
        .group_bit  (grp_q),
        .ring_lo    (cfg_start_pg),
        .ring_hi    (cfg_stop_pg),
        .hdr        (hdr),
        .nxt_pg     (nxt_pg)
    );

    assign in_ready = (st == ST_IDLE) || (st == ST_DATA) || (st == ST_DROP);
    assign fire     = in_valid && in_ready;

    always_comb begin
        st_n    = st;
        len_n   = len_q;
        hidx_n  = hidx_q;
        grp_n   = grp_q;
        fpg_n   = fpg_q;
        wp_load = 1'b0;
        wp_step = 1'b0;
        wr_en   = 1'b0;
        wr_addr = wp_addr;
        wr_data = in_data;
        done    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (fire && in_sof) begin
                    if (fits) begin
                        wp_load = 1'b1;
                        wr_en   = 1'b1;
                        len_n   = LEN_W'(1);
                        grp_n   = in_data[0];
                        fpg_n   = cur_pg;
                        hidx_n  = '0;
                        if (!in_eof)
                            st_n = ST_DATA;
                        else if (LEN_W'(1) < MIN_L)
                            st_n = ST_PAD;
                        else
                            st_n = ST_HDR;
                    end else if (!in_eof) begin
                        st_n = ST_DROP;
                    end
                end
            end
            ST_DATA: begin
                if (fire) begin
                    wr_en   = 1'b1;
                    wp_step = 1'b1;
                    len_n   = len_q + LEN_W'(1);
                    if (in_eof)
                        st_n = (len_n < MIN_L) ? ST_PAD : ST_HDR;
                end
            end
            ST_DROP: begin
                if (fire && in_eof)
                    st_n = ST_IDLE;
            end
            ST_PAD: begin
                wr_en   = 1'b1;
                wr_data = 8'h00;
                wp_step = 1'b1;
                len_n   = len_q + LEN_W'(1);
                if (len_n >= MIN_L)
                    st_n = ST_HDR;
            end
            ST_HDR: begin
                wr_en   = 1'b1;
                wr_addr = {fpg_q, 8'(hidx_q)};
                wr_data = hdr[8*hidx_q +: 8];
                hidx_n  = hidx_q + 2'd1;
                if (hidx_q == 2'd3) begin
                    done = 1'b1;
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            len_q     <= '0;
            hidx_q    <= '0;
            grp_q     <= 1'b0;
            fpg_q     <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            cur_pg    <= '0;
            rx_status <= '0;
            rx_irq    <= 1'b0;
        end else begin
            st        <= st_n;
            len_q     <= len_n;
            hidx_q    <= hidx_n;
            grp_q     <= grp_n;
            fpg_q     <= fpg_n;
            mem_we    <= wr_en;
            mem_addr  <= wr_addr;
            mem_wdata <= wr_data;
            if (irq_clr)
                rx_irq <= 1'b0;
            if (cur_pg_load)
                cur_pg <= cur_pg_wdata;
            if (done) begin
                cur_pg    <= nxt_pg;
                rx_status <= hdr.status;
                rx_irq    <= 1'b1;
            end
        end
    end

    // R6: every write lands inside the configured ring
    p_addr_in_ring_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_we && (cfg_start_pg < cfg_stop_pg)) |->
            (mem_addr >= {cfg_start_pg, 8'h00} && mem_addr < {cfg_stop_pg, 8'h00}));

    // R4: a padding cycle emits a zero byte on the next cycle
    p_pad_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PAD) |=> (mem_we && mem_wdata == 8'h00));

    // R3: drained bytes never reach memory
    p_drop_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DROP) |=> !mem_we);

    // R9: the flag rises together with the last header write
    p_irq_with_hdr_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_irq) |-> (mem_we && mem_addr[7:0] == 8'd3 && rx_status[0]));

    // R9: current page moves only on completion or host load
    p_curpg_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (!done && !cur_pg_load) |=> $stable(cur_pg));

    // R10: ready only drops right after an end byte
    p_ready_drop_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) |-> $past(in_valid && in_eof));

endmodule

// File: tb/rxr_ring_writer_test.sv
module rxr_ring_writer_test;

    localparam int CLK_NS = 10;
    localparam int PG_W   = 8;
    localparam int R_LO   = 2;
    localparam int R_HI   = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            halt = 1'b0;
    logic [PG_W-1:0] cfg_start_pg = PG_W'(R_LO);
    logic [PG_W-1:0] cfg_stop_pg  = PG_W'(R_HI);
    logic [PG_W-1:0] cfg_bndry_pg = PG_W'(R_LO);
    logic            cur_pg_load = 1'b0;
    logic [PG_W-1:0] cur_pg_wdata = '0;
    logic            irq_clr = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_sof = 1'b0;
    logic            in_eof = 1'b0;
    logic [7:0]      in_data = '0;
    logic            in_ready;
    logic            mem_we;
    logic [PG_W+7:0] mem_addr;
    logic [7:0]      mem_wdata;
    logic [PG_W-1:0] cur_pg;
    logic [7:0]      rx_status;
    logic            rx_irq;

    rxr_ring_writer #(.PG_W(PG_W)) uut (
        .clk(clk), .rst(rst), .halt(halt),
        .cfg_start_pg(cfg_start_pg), .cfg_stop_pg(cfg_stop_pg), .cfg_bndry_pg(cfg_bndry_pg),
        .cur_pg_load(cur_pg_load), .cur_pg_wdata(cur_pg_wdata), .irq_clr(irq_clr),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cur_pg(cur_pg), .rx_status(rx_status), .rx_irq(rx_irq)
    );

    always #(CLK_NS/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int wcnt   = 0;
    int stalls = 0;
    bit finished = 1'b0;
    logic [7:0] act [int];

    always @(negedge clk) begin
        if (!rst && mem_we) begin
            act[int'(mem_addr)] = mem_wdata;
            wcnt++;
        end
    end

    task automatic chk(input string tag, input int a, input int e);
        checks++;
        if (a != e) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
        end
    endtask

    function automatic logic [7:0] byte_of(input int i, input int seed, input bit grp);
        if (i == 0)
            return (8'(seed) & 8'hFE) | {7'd0, grp};
        return 8'(i * 7 + seed);
    endfunction

    task automatic send_frame(input int n, input int seed, input bit grp, output bit rdy_after);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == n - 1);
            in_data  = byte_of(i, seed, grp);
            while (!in_ready) begin
                stalls++;
                @(negedge clk);
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid  = 1'b0;
        in_sof    = 1'b0;
        in_eof    = 1'b0;
        rdy_after = in_ready;
    endtask

    task automatic run_frame(input int n, input int seed, input bit grp, input int c, input int b);
        int  free_b, neff, nxt, bad, base, a;
        bit  ok, rdy_after;
        logic [7:0] st;
        @(negedge clk);
        cur_pg_load  = 1'b1;
        cur_pg_wdata = PG_W'(c);
        cfg_bndry_pg = PG_W'(b);
        irq_clr      = 1'b1;
        @(negedge clk);
        cur_pg_load = 1'b0;
        irq_clr     = 1'b0;
        act.delete();
        wcnt = 0;
        send_frame(n, seed, grp, rdy_after);
        repeat (80) @(negedge clk);
        if (c < b) free_b = (b - c) * 256;
        else       free_b = (R_HI - R_LO) * 256 - (c - b) * 256;
        ok   = !halt && (free_b >= 1518);
        neff = (n < 60) ? 60 : n;
        if (!ok) begin
            chk("R1 R2 R3 no writes on reject", wcnt, 0);
            chk("R3 cur page held on reject", int'(cur_pg), c);
            chk("R3 no flag on reject", int'(rx_irq), 0);
        end else begin
            nxt = c + (neff + 8 + 255) / 256;
            if (nxt >= R_HI) nxt -= (R_HI - R_LO);
            st   = grp ? 8'h21 : 8'h01;
            base = c * 256;
            bad  = 0;
            chk("R1 R4 write count", wcnt, 4 + neff);
            for (int i = 0; i < neff; i++) begin
                a = base + 4 + i;
                if (a >= R_HI * 256) a -= (R_HI - R_LO) * 256;
                if (!act.exists(a) || act[a] != ((i < n) ? byte_of(i, seed, grp) : 8'h00))
                    bad++;
            end
            chk("R4 R6 payload and padding bytes", bad, 0);
            chk("R5 hdr status", act.exists(base) ? int'(act[base]) : -1, int'(st));
            chk("R5 hdr next page", act.exists(base + 1) ? int'(act[base + 1]) : -1, nxt);
            chk("R5 hdr len lo", act.exists(base + 2) ? int'(act[base + 2]) : -1, (neff + 4) % 256);
            chk("R5 hdr len hi", act.exists(base + 3) ? int'(act[base + 3]) : -1, (neff + 4) / 256);
            chk("R7 R9 cur page advanced", int'(cur_pg), nxt);
            chk("R9 flag set", int'(rx_irq), 1);
            chk("R8 status register", int'(rx_status), int'(st));
            chk("R10 ready low after end byte", int'(rdy_after), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 ready after reset", int'(in_ready), 1);
        chk("R9 flag clear after reset", int'(rx_irq), 0);
        chk("R9 cur page after reset", int'(cur_pg), 0);

        // R11: host load of the current page
        cur_pg_load = 1'b1; cur_pg_wdata = 8'd6;
        @(negedge clk);
        cur_pg_load = 1'b0;
        chk("R11 cur page load", int'(cur_pg), 6);

        // R12: bytes without a start marker while idle
        wcnt = 0;
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 4); in_data = 8'(i);
            @(negedge clk);
        end
        in_valid = 1'b0; in_eof = 1'b0;
        repeat (5) @(negedge clk);
        chk("R12 stray bytes write nothing", wcnt, 0);
        chk("R12 stray bytes keep cur page", int'(cur_pg), 6);

        // R1 R3: every current/boundary pair in the ring
        for (int c = R_LO; c < R_HI; c++)
            for (int b = R_LO; b < R_HI; b++)
                run_frame(10, c * 8 + b, 1'b0, c, b);

        // R2: halted receiver
        halt = 1'b1;
        run_frame(20, 5, 1'b0, 3, 3);
        halt = 1'b0;

        // R4-R8: lengths around padding and page edges, starting in the last page
        run_frame(1,    17, 1'b1, 9, 9);
        run_frame(59,   33, 1'b0, 9, 9);
        run_frame(60,   41, 1'b1, 9, 9);
        run_frame(61,   12, 1'b0, 9, 9);
        run_frame(247,  90, 1'b1, 9, 9);
        run_frame(248,  91, 1'b0, 9, 9);
        run_frame(249,  92, 1'b1, 9, 9);
        run_frame(253,  93, 1'b0, 8, 8);
        run_frame(1514, 77, 1'b1, 9, 9);
        run_frame(700,  55, 1'b0, 4, 3);

        // R9: clearing the flag
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk("R9 flag cleared", int'(rx_irq), 0);
        chk("R10 no stalls during payload", stalls, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule